// File: doc/BRIEF.md
# Multi-Sector Erase Sequencer with Status Bits

This block takes the sector-erase part of a flash command interface. A command decoder in front of it turns the bus traffic into single-cycle strobes. The block collects the sectors to erase, waits out a collection window, runs a timed model of the erase and reports progress on four status bits. The first erase confirm opens the collection window. Each further confirm that arrives while the window is open adds its sector to the set and starts the window again. When the window runs out without a new confirm, the block works through the collected sectors one at a time, starting with the lowest index. Each sector is first preprogrammed to all zeros and then erased with verified erase pulses. The array cells themselves are not part of the block: counters stand in for the time the cells take, and a verify input reports whether each erase pulse worked.

The erase can be paused so that the host can read data from other sectors, and then continued from where it stopped. A read aimed at a sector still waiting to be erased returns status instead of data. A reset command clears everything and returns to the idle state. When a sector cannot be erased within the allowed number of pulses, the block reports the failure and stays there until it receives a reset command.

Top module: `sector_erase_ctrl`

## Requirements
- R1: After the synchronous reset `rst`, the block is idle: `busy`=0, `sel_mask`=0, `st_done`=1, `st_timer`=0, `st_fail`=0, `st_toggle`=0.
- R2: In idle, an `erase_req` strobe opens the collection window: `busy`=1, `st_timer`=0, `st_done`=0, and `sel_mask` has only bit `erase_sect` set.
- R3: While the window is open, each `erase_req` ORs bit `erase_sect` into `sel_mask` and restarts the window. Erasing begins on the clock edge exactly WIN_CYC = CLK_MHZ*WIN_US edges after the last confirm was sampled, and `st_timer` rises on that edge.
- R4: While the window is open, a `cmd_reset` or `cmd_other` strobe aborts to idle and clears `sel_mask`. `suspend_req` and `resume_req` have no effect, and the window timing does not change.
- R5: Selected sectors are handled one after another, lowest index first. Each one spends PRE_CYC cycles in preprogram (`in_preprog`=1, `cur_sect` = its index), then PULSE_CYC cycles per erase pulse. A passing pulse clears its bit in `sel_mask`. The block returns to idle once `sel_mask` is empty, so with every pulse passing, `busy` falls WIN_CYC + n*(PRE_CYC+PULSE_CYC) edges after the last confirm, where n is the number of selected sectors.
- R6: Once erasing has begun, `erase_req`, `resume_req` and `cmd_other` are ignored: `sel_mask` and the completion time do not change. `cmd_reset` aborts to idle and clears `sel_mask`.
- R7: `suspend_req` during preprogram or erase freezes progress and gives `busy`=0, `st_done`=1, `st_timer`=1. `resume_req` continues the operation, so the suspend edge, the resume edge and every edge in between add to the completion time. While suspended, `cmd_reset` aborts to idle.
- R8: While suspended, a read (`rd_req`) of a sector whose bit is set in `sel_mask` returns status (`rd_is_status`=1) and toggles `st_toggle`. A read of any other sector returns array data (`rd_is_status`=0) and leaves `st_toggle` unchanged.
- R9: A read while the window is open, or while preprogram, erase or the failure state is active, returns status and toggles `st_toggle`. A read in idle returns array data and does not toggle. `rd_is_status` holds the result of the most recent read.
- R10: If `erase_ok` is low at the end of MAX_PULSES pulses in a row on one sector, the block enters the failure state: `st_fail`=1, `busy`=1, `st_done`=0. This happens MAX_PULSES*PULSE_CYC edges after that sector's erase phase begins. Suspend, resume and other commands are ignored there, and only `cmd_reset` leaves it. A pulse that fails followed by one that passes causes no failure.
- R11: `st_timer` is 0 in idle and in the window, and 1 during preprogram, erase, suspend and failure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| erase_req | input | 1 | Sector-erase confirm strobe |
| erase_sect | input | SW | Sector index of the confirm |
| suspend_req | input | 1 | Erase-suspend strobe |
| resume_req | input | 1 | Erase-resume strobe |
| cmd_reset | input | 1 | Reset command strobe |
| cmd_other | input | 1 | Any other decoded command |
| erase_ok | input | 1 | Cell verify result, sampled at the end of each erase pulse |
| rd_req | input | 1 | Read strobe |
| rd_sect | input | SW | Sector addressed by the read |
| st_timer | output | 1 | 0 while the window counts or idle, 1 once erasing has begun |
| st_fail | output | 1 | Erase failure |
| st_toggle | output | 1 | Toggles on each read that returns status |
| st_done | output | 1 | 0 while the operation is active, 1 when idle or suspended |
| busy | output | 1 | Window, preprogram, erase or failure active |
| sel_mask | output | NUM_SECT | Sectors still to be erased |
| cur_sect | output | SW | Sector being worked on |
| in_preprog | output | 1 | Current sector is in its preprogram phase |
| rd_is_status | output | 1 | Last read returned status instead of data |

## Verification
Every strobe is sampled on one rising edge, and every result shows in the state register on that same edge. So the checks for mask, status and read results sample at the falling edge right after the strobe. The bench counts edges from the last confirm. It expects `st_timer` to still be 0 after WIN_CYC-1 edges and to be 1 after WIN_CYC edges. Phase changes and the fall of `busy` are checked on both sides of the edge the requirement predicts. Each suspended interval is added to the remaining progress, and the ignored strobes during erase are counted against the same total.

// File: rtl/sec_pkg.sv
package sec_pkg;
  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_WIN  = 3'd1,
    S_PRE  = 3'd2,
    S_ERS  = 3'd3,
    S_SUSP = 3'd4,
    S_FAIL = 3'd5
  } sec_state_t;
endpackage

// File: rtl/sec_lsb_pick.sv
// Returns the index of the lowest set bit of a mask (0 when the mask is empty).
module sec_lsb_pick #(
  parameter int N  = 8,
  parameter int SW = 3
) (
  input  logic [N-1:0]  mask,
  output logic [SW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (mask[i]) idx = SW'(i);
    end
  end
endmodule

// File: rtl/sec_cycle_timer.sv
// Shared phase counter: clear has priority, otherwise count while enabled.
module sec_cycle_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          en,
  output logic [CW-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (en)    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sec_read_status.sv
// Decides whether a read returns status and drives the toggle bit.
module sec_read_status #(
  parameter int N  = 8,
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_req,
  input  logic [SW-1:0] rd_sect,
  input  logic          is_idle,
  input  logic          is_susp,
  input  logic [N-1:0]  mask,
  output logic          toggle,
  output logic          is_status
);
  logic stat_now;

  assign stat_now = !is_idle && !(is_susp && !mask[rd_sect]);

  always_ff @(posedge clk) begin
    if (rst) begin
      toggle    <= 1'b0;
      is_status <= 1'b0;
    end else if (rd_req) begin
      is_status <= stat_now;
      if (stat_now) toggle <= ~toggle;
    end
  end
endmodule

// File: rtl/sector_erase_ctrl.sv
module sector_erase_ctrl
  import sec_pkg::*;
#(
  parameter int NUM_SECT   = 8,
  parameter int CLK_MHZ    = 50,
  parameter int WIN_US     = 100,
  parameter int PRE_CYC    = 1000,
  parameter int PULSE_CYC  = 2000,
  parameter int MAX_PULSES = 4,
  localparam int SW = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                erase_req,
  input  logic [SW-1:0]       erase_sect,
  input  logic                suspend_req,
  input  logic                resume_req,
  input  logic                cmd_reset,
  input  logic                cmd_other,
  input  logic                erase_ok,
  input  logic                rd_req,
  input  logic [SW-1:0]       rd_sect,
  output logic                st_timer,
  output logic                st_fail,
  output logic                st_toggle,
  output logic                st_done,
  output logic                busy,
  output logic [NUM_SECT-1:0] sel_mask,
  output logic [SW-1:0]       cur_sect,
  output logic                in_preprog,
  output logic                rd_is_status
);
  localparam int WIN_CYC = CLK_MHZ * WIN_US;
  localparam int M1      = (WIN_CYC > PRE_CYC) ? WIN_CYC : PRE_CYC;
  localparam int CMAX    = (M1 > PULSE_CYC) ? M1 : PULSE_CYC;
  localparam int CW      = $clog2(CMAX + 1);
  localparam int PW      = $clog2(MAX_PULSES + 1);
  localparam logic [NUM_SECT-1:0] ONE = {{(NUM_SECT-1){1'b0}}, 1'b1};

  sec_state_t          state, st_n;
  logic [NUM_SECT-1:0] mask_q, mask_n;
  logic [SW-1:0]       act_q, act_n, pick_idx;
  logic [PW-1:0]       pul_q, pul_n;
  logic                ret_pre_q, ret_pre_n;
  logic                t_clr, t_en;
  logic [CW-1:0]       cnt;
  logic [NUM_SECT-1:0] se_bit, act_bit;

  assign se_bit  = ONE << erase_sect;
  assign act_bit = ONE << act_q;

  sec_cycle_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst(rst), .clr(t_clr), .en(t_en), .cnt(cnt)
  );

  sec_lsb_pick #(.N(NUM_SECT), .SW(SW)) u_pick (
    .mask(mask_n), .idx(pick_idx)
  );

  always_comb begin
    st_n      = state;
    mask_n    = mask_q;
    act_n     = act_q;
    pul_n     = pul_q;
    ret_pre_n = ret_pre_q;
    t_clr     = 1'b0;
    t_en      = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (erase_req) begin
          st_n   = S_WIN;
          mask_n = se_bit;
          t_clr  = 1'b1;
        end
      end
      S_WIN: begin
        if (cmd_reset || cmd_other) begin
          st_n   = S_IDLE;
          mask_n = '0;
          t_clr  = 1'b1;
        end else if (erase_req) begin
          mask_n = mask_q | se_bit;
          t_clr  = 1'b1;
        end else if (cnt == CW'(WIN_CYC - 1)) begin
          st_n  = S_PRE;
          act_n = pick_idx;
          t_clr = 1'b1;
        end else begin
          t_en = 1'b1;
        end
      end
      S_PRE: begin
        if (cmd_reset) begin
          st_n   = S_IDLE;
          mask_n = '0;
          t_clr  = 1'b1;
        end else if (suspend_req) begin
          st_n      = S_SUSP;
          ret_pre_n = 1'b1;
        end else if (cnt == CW'(PRE_CYC - 1)) begin
          st_n  = S_ERS;
          pul_n = '0;
          t_clr = 1'b1;
        end else begin
          t_en = 1'b1;
        end
      end
      S_ERS: begin
        if (cmd_reset) begin
          st_n   = S_IDLE;
          mask_n = '0;
          t_clr  = 1'b1;
        end else if (suspend_req) begin
          st_n      = S_SUSP;
          ret_pre_n = 1'b0;
        end else if (cnt == CW'(PULSE_CYC - 1)) begin
          t_clr = 1'b1;
          if (erase_ok) begin
            mask_n = mask_q & ~act_bit;
            if (mask_n != '0) begin
              st_n  = S_PRE;
              act_n = pick_idx;
            end else begin
              st_n = S_IDLE;
            end
          end else if (pul_q == PW'(MAX_PULSES - 1)) begin
            st_n = S_FAIL;
          end else begin
            pul_n = pul_q + 1'b1;
          end
        end else begin
          t_en = 1'b1;
        end
      end
      S_SUSP: begin
        if (cmd_reset) begin
          st_n   = S_IDLE;
          mask_n = '0;
          t_clr  = 1'b1;
        end else if (resume_req) begin
          st_n = ret_pre_q ? S_PRE : S_ERS;
        end
      end
      S_FAIL: begin
        if (cmd_reset) begin
          st_n   = S_IDLE;
          mask_n = '0;
          t_clr  = 1'b1;
        end
      end
      default: begin
        st_n   = S_IDLE;
        mask_n = '0;
        t_clr  = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      mask_q    <= '0;
      act_q     <= '0;
      pul_q     <= '0;
      ret_pre_q <= 1'b0;
    end else begin
      state     <= st_n;
      mask_q    <= mask_n;
      act_q     <= act_n;
      pul_q     <= pul_n;
      ret_pre_q <= ret_pre_n;
    end
  end

  sec_read_status #(.N(NUM_SECT), .SW(SW)) u_rd (
    .clk(clk), .rst(rst), .rd_req(rd_req), .rd_sect(rd_sect),
    .is_idle(state == S_IDLE), .is_susp(state == S_SUSP), .mask(mask_q),
    .toggle(st_toggle), .is_status(rd_is_status)
  );

  assign busy       = (state == S_WIN) || (state == S_PRE) || (state == S_ERS) || (state == S_FAIL);
  assign st_timer   = (state == S_PRE) || (state == S_ERS) || (state == S_SUSP) || (state == S_FAIL);
  assign st_fail    = (state == S_FAIL);
  assign st_done    = (state == S_IDLE) || (state == S_SUSP);
  assign sel_mask   = mask_q;
  assign cur_sect   = act_q;
  assign in_preprog = (state == S_PRE);
endmodule

// File: rtl/sector_erase_chk.sv
module sector_erase_chk #(
  parameter int NUM_SECT = 8,
  localparam int SW = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1
) (
  input logic                clk,
  input logic                rst,
  input logic                erase_req,
  input logic [SW-1:0]       erase_sect,
  input logic                suspend_req,
  input logic                cmd_reset,
  input logic                cmd_other,
  input logic                rd_req,
  input logic                st_timer,
  input logic                st_fail,
  input logic                st_toggle,
  input logic                st_done,
  input logic                busy,
  input logic [NUM_SECT-1:0] sel_mask,
  input logic                rd_is_status
);
  logic [NUM_SECT-1:0] req_bit;
  assign req_bit = {{(NUM_SECT-1){1'b0}}, 1'b1} << erase_sect;

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (!busy && sel_mask == '0 && st_done && !st_fail && !st_timer));

  // R3
  window_add_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !st_timer && erase_req && !cmd_reset && !cmd_other)
      |=> ((sel_mask & $past(req_bit)) != '0));

  // R6
  erase_no_add_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && st_timer && !st_fail && !cmd_reset && !suspend_req)
      |=> ((sel_mask & ~$past(sel_mask)) == '0));

  // R7
  susp_keeps_set_chk: assert property (@(posedge clk) disable iff (rst)
    (st_timer && !busy) |-> (sel_mask != '0 && st_done));

  // R10
  fail_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (st_fail && !cmd_reset) |=> (st_fail && busy && !st_done));

  // R9
  idle_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !busy && !st_timer) |=> (!rd_is_status && $stable(st_toggle)));
endmodule

bind sector_erase_ctrl sector_erase_chk #(.NUM_SECT(NUM_SECT)) u_chk (.*);

// File: tb/tb_sector_erase_ctrl.sv
module tb_sector_erase_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N    = 8;
  localparam int CMHZ = 4;
  localparam int WUS  = 5;
  localparam int W    = CMHZ * WUS;
  localparam int PRE  = 6;
  localparam int PUL  = 10;
  localparam int MAXP = 3;

  logic clk = 0, rst = 1;
  logic erase_req = 0, suspend_req = 0, resume_req = 0, cmd_reset = 0, cmd_other = 0;
  logic erase_ok = 1, rd_req = 0;
  logic [2:0] erase_sect = 0, rd_sect = 0;
  logic st_timer, st_fail, st_toggle, st_done, busy, in_preprog, rd_is_status;
  logic [N-1:0] sel_mask;
  logic [2:0] cur_sect;

  int checks = 0, errors = 0;
  bit done = 0;
  logic exp_tog = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sector_erase_ctrl #(.NUM_SECT(N), .CLK_MHZ(CMHZ), .WIN_US(WUS), .PRE_CYC(PRE),
                      .PULSE_CYC(PUL), .MAX_PULSES(MAXP)) dut (
    .clk(clk), .rst(rst), .erase_req(erase_req), .erase_sect(erase_sect),
    .suspend_req(suspend_req), .resume_req(resume_req), .cmd_reset(cmd_reset),
    .cmd_other(cmd_other), .erase_ok(erase_ok), .rd_req(rd_req), .rd_sect(rd_sect),
    .st_timer(st_timer), .st_fail(st_fail), .st_toggle(st_toggle), .st_done(st_done),
    .busy(busy), .sel_mask(sel_mask), .cur_sect(cur_sect), .in_preprog(in_preprog),
    .rd_is_status(rd_is_status)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_se(input int s);
    erase_req = 1; erase_sect = 3'(s); @(negedge clk); erase_req = 0;
  endtask
  task automatic do_sus; suspend_req = 1; @(negedge clk); suspend_req = 0; endtask
  task automatic do_res; resume_req = 1; @(negedge clk); resume_req = 0; endtask
  task automatic do_rcmd; cmd_reset = 1; @(negedge clk); cmd_reset = 0; endtask
  task automatic do_oth; cmd_other = 1; @(negedge clk); cmd_other = 0; endtask
  task automatic do_rd(input int s);
    rd_req = 1; rd_sect = 3'(s); @(negedge clk); rd_req = 0;
  endtask

  function automatic int lowest(input logic [N-1:0] m);
    for (int i = 0; i < N; i++) if (m[i]) return i;
    return 0;
  endfunction
  function automatic int popc(input logic [N-1:0] m);
    int c = 0;
    for (int i = 0; i < N; i++) c += int'(m[i]);
    return c;
  endfunction

  task automatic chk_idle(input string req);
    chk({req, " busy"}, busy, 0);
    chk({req, " mask"}, sel_mask, 0);
    chk({req, " done"}, st_done, 1);
    chk({req, " timer"}, st_timer, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    step(3); rst = 0; step(1);
    // R1 reset state
    chk_idle("R1");
    chk("R1 fail", st_fail, 0);
    chk("R1 toggle", st_toggle, 0);

    // R9 idle read returns array data
    do_rd(2);
    chk("R9 idle rd", rd_is_status, 0);
    chk("R9 idle tog", st_toggle, 0);

    // R2 open window, R9 read in window, R11/R5 timing
    do_se(5);
    chk("R2 busy", busy, 1); chk("R2 timer", st_timer, 0);
    chk("R2 done", st_done, 0); chk("R2 mask", sel_mask, 8'h20);
    do_rd(0); exp_tog = ~exp_tog;
    chk("R9 win rd", rd_is_status, 1); chk("R9 win tog", st_toggle, exp_tog);
    step(W - 2);
    chk("R3 window edge-1", st_timer, 0);
    step(1);
    chk("R11 timer up", st_timer, 1); chk("R5 preprog", in_preprog, 1);
    chk("R5 sect", cur_sect, 5);
    step(PRE - 1); chk("R5 pre end-1", in_preprog, 1);
    step(1); chk("R5 pre->erase", in_preprog, 0);
    step(PUL - 1); chk("R5 busy end-1", busy, 1);
    step(1); chk_idle("R5");

    // R4 abort by other command and reset command; suspend/resume ignored
    do_se(1); step(3); do_sus; do_res;
    chk("R4 sus ign busy", busy, 1); chk("R4 sus ign timer", st_timer, 0);
    do_oth; chk_idle("R4 oth");
    do_se(2); step(2); do_rcmd; chk_idle("R4 rcmd");
    do_se(3); do_sus; do_res; step(W - 3);
    chk("R4 timing kept", st_timer, 0);
    step(1); chk("R4 timing edge", st_timer, 1);
    step(PRE + PUL); chk_idle("R4 finish");

    // R3 accumulate and restart; R5 lowest first
    do_se(6); step(W - 3); do_se(2); step(W - 1);
    chk("R3 restart timer", st_timer, 0); chk("R3 mask", sel_mask, 8'h44);
    step(1); chk("R5 lowest first", cur_sect, 2);
    step(PRE + PUL);
    chk("R5 second sect", cur_sect, 6); chk("R5 second pre", in_preprog, 1);
    chk("R5 bit cleared", sel_mask, 8'h40);
    step(PRE + PUL - 1); chk("R5 two end-1", busy, 1);
    step(1); chk_idle("R5 two");

    // R6 ignored strobes during erase, then abort by reset command
    do_se(4); step(W); do_se(7); do_res; do_oth;
    chk("R6 mask", sel_mask, 8'h10); chk("R6 busy", busy, 1);
    step(PRE + PUL - 4); chk("R6 end-1", busy, 1);
    step(1); chk_idle("R6 done");
    do_se(0); step(W + 2); do_rcmd; chk_idle("R6 rcmd");

    // R7 suspend/resume with R8 reads
    do_se(1); do_se(3); step(W); step(PRE + 3);
    do_sus;
    chk("R7 busy", busy, 0); chk("R7 done", st_done, 1);
    chk("R7 timer", st_timer, 1); chk("R7 mask", sel_mask, 8'h0A);
    do_rd(3); exp_tog = ~exp_tog;
    chk("R8 sel rd", rd_is_status, 1); chk("R8 sel tog", st_toggle, exp_tog);
    do_rd(5);
    chk("R8 other rd", rd_is_status, 0); chk("R8 other tog", st_toggle, exp_tog);
    do_rd(1); exp_tog = ~exp_tog;
    chk("R8 cur rd", rd_is_status, 1); chk("R8 cur tog", st_toggle, exp_tog);
    step(7); chk("R7 held", busy, 0);
    do_res;
    chk("R7 resumed", busy, 1); chk("R7 phase", in_preprog, 0); chk("R7 sect", cur_sect, 1);
    step(2 * (PRE + PUL) - (PRE + 3) - 1); chk("R7 end-1", busy, 1);
    step(1); chk_idle("R7 done");
    do_se(6); step(W + 2); do_sus; do_res;
    chk("R7 pre resume", in_preprog, 1);
    step(PRE + PUL - 2 - 1); chk("R7 pre end-1", busy, 1);
    step(1); chk_idle("R7 pre done");
    do_se(2); step(W + 1); do_sus; do_rcmd; chk_idle("R7 rcmd");

    // R10 failure after MAXP bad pulses
    erase_ok = 0;
    do_se(2); step(W + PRE + MAXP * PUL - 1);
    chk("R10 before", st_fail, 0); chk("R10 before busy", busy, 1);
    step(1);
    chk("R10 fail", st_fail, 1); chk("R10 busy", busy, 1);
    chk("R10 done", st_done, 0); chk("R11 fail timer", st_timer, 1);
    do_sus; do_res; do_oth;
    chk("R10 sticky", st_fail, 1); chk("R10 sticky busy", busy, 1);
    do_rd(0); exp_tog = ~exp_tog;
    chk("R9 fail rd", rd_is_status, 1); chk("R9 fail tog", st_toggle, exp_tog);
    do_rcmd; chk_idle("R10 rcmd"); chk("R10 cleared", st_fail, 0);
    do_se(4); step(W + PRE + PUL); erase_ok = 1;
    chk("R10 retry nofail", st_fail, 0);
    step(PUL - 1); chk("R10 retry end-1", sel_mask, 8'h10);
    step(1); chk_idle("R10 retry");

    // Random accumulation trials (R3, R5, R6)
    void'($urandom(32'd20240611));
    for (int t = 0; t < 25; t++) begin
      int n, el, total;
      logic [N-1:0] em;
      n = 1 + int'($urandom % 4);
      em = '0;
      for (int k = 0; k < n; k++) begin
        int s;
        s = int'($urandom % N);
        em |= N'(1) << s;
        do_se(s);
        if (k < n - 1) step(int'($urandom % (W - 1)));
      end
      step(W - 1);
      chk("R3 rnd mask", sel_mask, em); chk("R3 rnd timer", st_timer, 0);
      step(1);
      chk("R5 rnd first", cur_sect, lowest(em));
      total = W + popc(em) * (PRE + PUL);
      el = W;
      if ($urandom % 2) begin do_res; el++; end
      if ($urandom % 2) begin do_oth; el++; end
      step(total - el - 1); chk("R6 rnd end-1", busy, 1);
      step(1); chk("R5 rnd done", busy, 0); chk("R5 rnd mask", sel_mask, 0);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule